// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

Two 40-bit event counters watch per-cycle strobes from a processor core: data accesses on two lanes, line-fill beats, taken interrupts, bus ownership handshakes, pipe retirements and snoop results. Each counter has a 6-bit selector. The selector's code picks the event that counter accumulates. Several codes select a different event on counter 0 than on counter 1, so one code can give a pair of measurements. For example, counter 0 can count bus-ownership stall cycles while counter 1 counts ownership requests, and the ratio of the two is the mean stall.

Software reaches both counters and both selectors through a small synchronous register port. Each counter wraps silently at 2^40. Each counter also keeps a sticky overflow flag.

Miss counting stays accurate during a four-beat burst refill. After the first ready beat of a fill, further misses to the line being filled are not counted again until the fourth beat arrives.

Top module: `evt_ctr_unit`

## Requirements
- R1: After reset both counters, both selectors and both overflow flags read zero.
- R2: The register address selects the target as follows: 0 is counter 0, 1 is counter 1, 2 is selector 0 and 3 is selector 1. A selector takes wdata bits [5:0] and reads back zero-extended. A write is visible on reg_rdata_o after the next rising clock edge. Reads are combinational.
- R3: A register write to a counter replaces that counter's value even when an event would have incremented it in the same cycle.
- R4: Code 0x27 adds one per cycle in which irq_taken_i is high, on either counter.
- R5: Code 0x28 adds, per cycle, the number of valid access lanes (0, 1 or 2) whose TLB-walk and I/O qualifiers are both low, hit or miss alike.
- R6: Code 0x29 counts valid lanes with miss high and with TLB-walk and I/O low. A lane is not counted if it misses to the line currently being filled, from the cycle after the fill's first ready beat up to the cycle before its fourth beat. A miss in the same cycle as the first or fourth beat is counted.
- R7: Code 0x2A on counter 0 adds one per cycle from the first cycle with bus_req_i or snoop_hitm_i high until bus_gnt_i is seen. The grant cycle itself is not counted.
- R8: Code 0x2A on counter 1 adds one for each rising edge of bus_req_i.
- R9: Code 0x2B counts u_retire_i pulses on counter 0 and v_retire_i pulses on counter 1.
- R10: Code 0x2C counts hitm_other_i on counter 0 and shared_hit_i on counter 1.
- R11: Any other selector code leaves the counter unchanged, whatever events occur.
- R12: A counter wraps modulo 2^40. A carry out of bit 39 sets that counter's bit of ovf_o, which then stays set until the counter is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_vld_i | input | 2 | Data access valid, one bit per lane |
| acc_miss_i | input | 2 | Lane access missed the data cache |
| acc_tlb_i | input | 2 | Lane access belongs to TLB-miss handling |
| acc_io_i | input | 2 | Lane access targets I/O space |
| acc_line_i | input | 2*LINE_W | Line address per lane, lane 0 in the low bits |
| fill_rdy_i | input | 1 | Burst fill ready beat |
| fill_line_i | input | LINE_W | Line address of the fill |
| irq_taken_i | input | 1 | Maskable or non-maskable interrupt taken |
| bus_req_i | input | 1 | Bus ownership request |
| snoop_hitm_i | input | 1 | Snoop hit to a modified line, starts an ownership wait |
| bus_gnt_i | input | 1 | Bus ownership granted |
| u_retire_i | input | 1 | Instruction executed in the U pipe |
| v_retire_i | input | 1 | Instruction executed in the V pipe |
| hitm_other_i | input | 1 | Modified-line hit caused by the other processor |
| shared_hit_i | input | 1 | Hit to a shared line |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | CTR_W | Register write data |
| reg_rdata_o | output | CTR_W | Register read data |
| ovf_o | output | 2 | Sticky overflow flag per counter |

## Verification
Every event strobe in cycle N reaches a counter at the rising edge that closes cycle N. The bench therefore drives stimulus just after a falling edge, holds it for one full cycle, and reads the register port at the following falling edge once inputs are idle. Register writes follow the same one-edge timing. The fill-window cases place misses in the cycles of the first beat, the middle beats and the fourth beat, so both window edges are checked. The ownership-wait cases count the cycles from request to grant by hand, and the expected totals come from that count.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int LANES = 2;

  localparam logic [5:0] EV_IRQ   = 6'h27;
  localparam logic [5:0] EV_ACC   = 6'h28;
  localparam logic [5:0] EV_MISS  = 6'h29;
  localparam logic [5:0] EV_BUS   = 6'h2A;
  localparam logic [5:0] EV_PIPE  = 6'h2B;
  localparam logic [5:0] EV_SNOOP = 6'h2C;

  typedef struct packed {
    logic [LANES-1:0] acc;
    logic [LANES-1:0] miss;
    logic             irq;
    logic             wait_act;
    logic             req_edge;
    logic             u_ret;
    logic             v_ret;
    logic             hitm_oth;
    logic             shr_hit;
  } evt_vec_t;
endpackage

// File: rtl/evt_fill_track.sv
module evt_fill_track #(
  parameter int LINE_W = 26,
  parameter int BEATS  = 4,
  parameter int LANES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fill_rdy_i,
  input  logic [LINE_W-1:0]       fill_line_i,
  input  logic [LANES*LINE_W-1:0] acc_line_i,
  output logic [LANES-1:0]        supp_o
);
  localparam int BEAT_W = $clog2(BEATS);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS-1);

  logic              trk_vld_q;
  logic [LINE_W-1:0] trk_line_q;
  logic [BEAT_W-1:0] beat_q;
  logic              last_beat;

  assign last_beat = fill_rdy_i & trk_vld_q & (beat_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trk_vld_q  <= 1'b0;
      trk_line_q <= '0;
      beat_q     <= '0;
    end else if (fill_rdy_i) begin
      if (!trk_vld_q) begin
        trk_vld_q  <= 1'b1;
        trk_line_q <= fill_line_i;
        beat_q     <= BEAT_W'(1);
      end else if (last_beat) begin
        trk_vld_q <= 1'b0;
        beat_q    <= '0;
      end else begin
        beat_q <= beat_q + BEAT_W'(1);
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign supp_o[l] = trk_vld_q & ~last_beat &
                       (acc_line_i[l*LINE_W +: LINE_W] == trk_line_q);
  end

  assert_trk_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_beat |=> !trk_vld_q);
  assert_trk_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_rdy_i && !trk_vld_q) |=> (trk_vld_q && trk_line_q == $past(fill_line_i)));
endmodule

// File: rtl/evt_decode.sv
module evt_decode
  import evt_ctr_pkg::*;
#(
  parameter int CTR_IDX = 0,
  parameter int SEL_W   = 6
) (
  input  logic [SEL_W-1:0] sel_i,
  input  evt_vec_t         ev_i,
  output logic [1:0]       inc_o
);
  logic [1:0] acc_n, miss_n;
  logic       bus_ev, pipe_ev, snp_ev;

  assign acc_n  = {1'b0, ev_i.acc[0]}  + {1'b0, ev_i.acc[1]};
  assign miss_n = {1'b0, ev_i.miss[0]} + {1'b0, ev_i.miss[1]};

  // counter index picks the meaning of the paired codes
  if (CTR_IDX == 0) begin : g_c0
    assign bus_ev  = ev_i.wait_act;
    assign pipe_ev = ev_i.u_ret;
    assign snp_ev  = ev_i.hitm_oth;
  end else begin : g_c1
    assign bus_ev  = ev_i.req_edge;
    assign pipe_ev = ev_i.v_ret;
    assign snp_ev  = ev_i.shr_hit;
  end

  always_comb begin
    unique case (6'(sel_i))
      EV_IRQ:   inc_o = {1'b0, ev_i.irq};
      EV_ACC:   inc_o = acc_n;
      EV_MISS:  inc_o = miss_n;
      EV_BUS:   inc_o = {1'b0, bus_ev};
      EV_PIPE:  inc_o = {1'b0, pipe_ev};
      EV_SNOOP: inc_o = {1'b0, snp_ev};
      default:  inc_o = 2'd0;
    endcase
  end
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CTR_W = 40,
  parameter int SEL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_we_i,
  input  logic             sel_we_i,
  input  logic [CTR_W-1:0] wdata_i,
  input  logic [1:0]       inc_i,
  output logic [CTR_W-1:0] cnt_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             ovf_o
);
  logic [CTR_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic             ovf_q;
  logic [CTR_W:0]   sum;

  assign sum = {1'b0, cnt_q} + {{(CTR_W-1){1'b0}}, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (cnt_we_i) begin
      cnt_q <= wdata_i;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= sum[CTR_W-1:0];
      if (sum[CTR_W]) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= '0;
    else if (sel_we_i) sel_q <= wdata_i[SEL_W-1:0];
  end

  assign cnt_o = cnt_q;
  assign sel_o = sel_q;
  assign ovf_o = ovf_q;

  assert_wr_prio_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_q == $past(wdata_i));
  assert_ovf_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !cnt_we_i) |=> ovf_q);
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_we_i && inc_i == 2'd0) |=> $stable(cnt_q));
  assert_inc_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i <= 2'd2);
endmodule

// File: rtl/evt_ctr_unit.sv
module evt_ctr_unit
  import evt_ctr_pkg::*;
#(
  parameter int CTR_W  = 40,
  parameter int SEL_W  = 6,
  parameter int LINE_W = 26,
  parameter int BEATS  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              acc_vld_i,
  input  logic [1:0]              acc_miss_i,
  input  logic [1:0]              acc_tlb_i,
  input  logic [1:0]              acc_io_i,
  input  logic [2*LINE_W-1:0]     acc_line_i,
  input  logic                    fill_rdy_i,
  input  logic [LINE_W-1:0]       fill_line_i,
  input  logic                    irq_taken_i,
  input  logic                    bus_req_i,
  input  logic                    snoop_hitm_i,
  input  logic                    bus_gnt_i,
  input  logic                    u_retire_i,
  input  logic                    v_retire_i,
  input  logic                    hitm_other_i,
  input  logic                    shared_hit_i,
  input  logic                    reg_we_i,
  input  logic [1:0]              reg_addr_i,
  input  logic [CTR_W-1:0]        reg_wdata_i,
  output logic [CTR_W-1:0]        reg_rdata_o,
  output logic [1:0]              ovf_o
);
  localparam int NCTR = 2;
  localparam int PAD  = CTR_W - SEL_W;

  evt_vec_t         ev;
  logic [1:0]       supp, lane_ok;
  logic             wait_q, waiting, req_q;
  logic [CTR_W-1:0] cnt [NCTR];
  logic [SEL_W-1:0] sel [NCTR];
  logic [1:0]       inc [NCTR];

  evt_fill_track #(.LINE_W(LINE_W), .BEATS(BEATS), .LANES(LANES)) u_trk (
    .clk_i, .rst_ni, .fill_rdy_i, .fill_line_i, .acc_line_i, .supp_o(supp)
  );

  assign lane_ok = acc_vld_i & ~acc_tlb_i & ~acc_io_i;
  // wait opens on request or snoop-modified, closes on grant
  assign waiting = (bus_req_i | snoop_hitm_i | wait_q) & ~bus_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      wait_q <= waiting;
      req_q  <= bus_req_i;
    end
  end

  always_comb begin
    ev.acc      = lane_ok;
    ev.miss     = lane_ok & acc_miss_i & ~supp;
    ev.irq      = irq_taken_i;
    ev.wait_act = waiting;
    ev.req_edge = bus_req_i & ~req_q;
    ev.u_ret    = u_retire_i;
    ev.v_ret    = v_retire_i;
    ev.hitm_oth = hitm_other_i;
    ev.shr_hit  = shared_hit_i;
  end

  for (genvar c = 0; c < NCTR; c++) begin : g_ctr
    logic cwe, swe;
    assign cwe = reg_we_i & ~reg_addr_i[1] & (reg_addr_i[0] == 1'(c));
    assign swe = reg_we_i &  reg_addr_i[1] & (reg_addr_i[0] == 1'(c));

    evt_decode #(.CTR_IDX(c), .SEL_W(SEL_W)) u_dec (
      .sel_i(sel[c]), .ev_i(ev), .inc_o(inc[c])
    );

    evt_counter #(.CTR_W(CTR_W), .SEL_W(SEL_W)) u_cnt (
      .clk_i, .rst_ni, .cnt_we_i(cwe), .sel_we_i(swe), .wdata_i(reg_wdata_i),
      .inc_i(inc[c]), .cnt_o(cnt[c]), .sel_o(sel[c]), .ovf_o(ovf_o[c])
    );

    assert_unassigned_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel[c] < SEL_W'(EV_IRQ) || sel[c] > SEL_W'(EV_SNOOP)) |-> inc[c] == 2'd0);
  end

  always_comb begin
    unique case (reg_addr_i)
      2'd0: reg_rdata_o = cnt[0];
      2'd1: reg_rdata_o = cnt[1];
      2'd2: reg_rdata_o = {{PAD{1'b0}}, sel[0]};
      default: reg_rdata_o = {{PAD{1'b0}}, sel[1]};
    endcase
  end

  assert_grant_ends_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_gnt_i |=> !wait_q);
  assert_req_edge_once_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && req_q) |-> inc[1] == 2'd0 || sel[1] != SEL_W'(EV_BUS));
endmodule

// File: tb/sim_evt_ctr_unit.sv
module sim_evt_ctr_unit;
  localparam int  CLK_P  = 10;
  localparam int  CTR_W  = 40;
  localparam int  LINE_W = 26;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] acc_vld, acc_miss, acc_tlb, acc_io;
  logic [LINE_W-1:0] ln0, ln1, fill_line;
  logic fill_rdy, irq, breq, hitm, gnt, u_r, v_r, hoth, shr, we;
  logic [1:0] addr;
  logic [CTR_W-1:0] wdata, rdata;
  logic [1:0] ovf;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  evt_ctr_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_vld_i(acc_vld), .acc_miss_i(acc_miss),
    .acc_tlb_i(acc_tlb), .acc_io_i(acc_io), .acc_line_i({ln1, ln0}),
    .fill_rdy_i(fill_rdy), .fill_line_i(fill_line), .irq_taken_i(irq),
    .bus_req_i(breq), .snoop_hitm_i(hitm), .bus_gnt_i(gnt), .u_retire_i(u_r),
    .v_retire_i(v_r), .hitm_other_i(hoth), .shared_hit_i(shr), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ovf_o(ovf)
  );

  task automatic chk(input string req, input logic [CTR_W-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    acc_vld = 0; acc_miss = 0; acc_tlb = 0; acc_io = 0; ln0 = 0; ln1 = 0;
    fill_rdy = 0; fill_line = 0; irq = 0; breq = 0; hitm = 0; gnt = 0;
    u_r = 0; v_r = 0; hoth = 0; shr = 0; we = 0;
  endtask

  task automatic step(); @(negedge clk); idle(); endtask

  task automatic wr(input logic [1:0] a, input logic [CTR_W-1:0] d);
    we = 1; addr = a; wdata = d; step();
  endtask

  task automatic rd(input logic [1:0] a, output logic [CTR_W-1:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic setup(input logic [5:0] s0, s1);
    wr(2'd2, 40'(s0)); wr(2'd3, 40'(s1)); wr(2'd0, 0); wr(2'd1, 0);
  endtask

  task automatic expect2(input string req, input logic [CTR_W-1:0] e0, e1);
    logic [CTR_W-1:0] v;
    rd(2'd0, v); chk({req, " ctr0"}, v, e0);
    rd(2'd1, v); chk({req, " ctr1"}, v, e1);
  endtask

  task automatic t_reset();
    logic [CTR_W-1:0] v;
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R1 reg", v, 0); end
    chk("R1 ovf", 40'(ovf), 0);
  endtask

  task automatic t_regport();
    logic [CTR_W-1:0] v;
    wr(2'd2, 40'hFF_FFFF_FFEA);
    rd(2'd2, v); chk("R2 sel0 low bits", v, 40'h2A);
    wr(2'd3, 40'h15); rd(2'd3, v); chk("R2 sel1", v, 40'h15);
    wr(2'd1, 40'h12_3456_789A); rd(2'd1, v); chk("R2 ctr1", v, 40'h12_3456_789A);
    rd(2'd0, v); chk("R2 ctr0 untouched", v, 0);
  endtask

  task automatic t_irq_prio();
    setup(6'h27, 6'h27);
    irq = 1; step();
    step();
    irq = 1; step();
    irq = 1; step();
    expect2("R4", 3, 3);
    irq = 1; we = 1; addr = 2'd0; wdata = 100; step();
    expect2("R3", 100, 4);
  endtask

  task automatic t_access();
    setup(6'h28, 6'h29);
    acc_vld = 2'b11; step();
    acc_vld = 2'b11; acc_miss = 2'b11; acc_tlb = 2'b01; acc_io = 2'b10; step();
    acc_vld = 2'b11; acc_miss = 2'b01; acc_tlb = 2'b10; step();
    acc_vld = 2'b10; acc_miss = 2'b10; step();
    expect2("R5/R6 qualifiers", 4, 2);
  endtask

  task automatic t_dedup();
    setup(6'h29, 6'h28);
    acc_vld = 2'b01; acc_miss = 2'b01; ln0 = 5; step();
    fill_rdy = 1; fill_line = 5; acc_vld = 2'b01; acc_miss = 2'b01; ln0 = 5; step();
    acc_vld = 2'b11; acc_miss = 2'b11; ln0 = 5; ln1 = 6; step();
    fill_rdy = 1; fill_line = 5; acc_vld = 2'b10; acc_miss = 2'b10; ln1 = 5; step();
    fill_rdy = 1; fill_line = 5; step();
    expect2("R6 window", 3, 5);
    fill_rdy = 1; fill_line = 5; acc_vld = 2'b01; acc_miss = 2'b01; ln0 = 5; step();
    acc_vld = 2'b01; acc_miss = 2'b01; ln0 = 5; step();
    expect2("R6 after fourth beat", 5, 7);
  endtask

  task automatic t_bus();
    setup(6'h2A, 6'h2A);
    breq = 1; step();
    breq = 1; step();
    breq = 1; step();
    breq = 1; gnt = 1; step();
    expect2("R7/R8 request wait", 3, 1);
    hitm = 1; step();
    step();
    gnt = 1; step();
    step();
    expect2("R7 snoop wait", 5, 1);
    breq = 1; step();
    breq = 1; gnt = 1; step();
    expect2("R8 second request", 6, 2);
  endtask

  task automatic t_pipe_snoop();
    setup(6'h2B, 6'h2B);
    u_r = 1; step();
    u_r = 1; v_r = 1; step();
    u_r = 1; step();
    v_r = 1; hoth = 1; shr = 1; step();
    expect2("R9", 3, 2);
    setup(6'h2C, 6'h2C);
    hoth = 1; step();
    shr = 1; u_r = 1; step();
    hoth = 1; shr = 1; step();
    shr = 1; step();
    expect2("R10", 2, 3);
  endtask

  task automatic t_unassigned();
    wr(2'd2, 40'h3F); wr(2'd3, 40'h00); wr(2'd0, 7); wr(2'd1, 9);
    acc_vld = 2'b11; acc_miss = 2'b11; irq = 1; breq = 1; u_r = 1; v_r = 1;
    hoth = 1; shr = 1; step();
    acc_vld = 2'b11; irq = 1; hitm = 1; step();
    expect2("R11", 7, 9);
  endtask

  task automatic t_wrap();
    wr(2'd2, 40'h28); wr(2'd0, {CTR_W{1'b1}});
    acc_vld = 2'b11; step();
    expect2("R12 wrap", 1, 9);
    chk("R12 ovf set", 40'(ovf), 40'b01);
    step();
    chk("R12 ovf sticky", 40'(ovf), 40'b01);
    wr(2'd0, 0);
    chk("R12 ovf cleared", 40'(ovf), 0);
  endtask

  initial begin
    idle(); addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regport();
    t_irq_prio();
    t_access();
    t_dedup();
    t_bus();
    t_pipe_snoop();
    t_unassigned();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule